// File: doc/BRIEF.md
# Four-Mode Addressable Latch Decoder

This block holds eight single-bit outputs written from one data input through a 3-bit select. Two active-low controls, an enable (`en_ni`) and a clear (`clr_ni`), choose one of four behaviours on each cycle. In the first, the selected bit is written while the rest keep their values. In the second, nothing changes. In the third, the block works as a one-of-eight demultiplexer that puts the data on the selected output and drives every other output low. In the fourth, every output is cleared.

The design is a synchronous equivalent built from flip-flops. The controls are sampled on the rising clock edge, and the outputs are the registered state, so the outputs reflect a mode one cycle after it is applied. The demultiplexer pattern is written into the stored bits. A later hold therefore keeps that pattern. An asynchronous power-on reset, `rst_ni`, is separate from the functional clear and zeroes all bits.

Top module: `addr_latch_dec`

## Requirements
- R1: While rst_ni is low, q_o is 8'h00 asynchronously, and it stays 0 after rst_ni is released until a writing mode is applied.
- R2: The mode is decoded from {en_ni, clr_ni} as follows: 2'b01 is latch, 2'b11 is hold, 2'b00 is demultiplex and 2'b10 is clear.
- R3: In latch mode, one cycle later q_o[sel_i] equals d_i, and every other bit of q_o keeps its previous value.
- R4: In hold mode, q_o keeps its previous value whatever sel_i and d_i are.
- R5: In demultiplex mode, one cycle later q_o[sel_i] equals d_i and every other bit of q_o is 0.
- R6: In clear mode, one cycle later q_o is 8'h00 whatever sel_i and d_i are.
- R7: The pattern written by demultiplex mode is stored. A following hold keeps it, and a following latch changes only the selected bit of it.
- R8: Select value k addresses bit k of q_o, and sel_i[0] is the least significant select bit.
- R9: At most one bit of q_o differs from the previous cycle's value after a latch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all changes happen on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| en_ni | input | 1 | Active-low enable, one half of the mode select |
| clr_ni | input | 1 | Active-low clear, the other half of the mode select |
| sel_i | input | 3 | Bit select |
| d_i | input | 1 | Data input |
| q_o | output | 8 | Registered outputs |

## Verification
The hardest case to bring about is a demultiplex cycle that overwrites a varied stored pattern and is then followed by a hold or a latch. Only that sequence shows whether the demultiplex mode really loads the storage or merely masks the outputs. The vector table therefore first fills the register with a mixed pattern using latch writes. It then demultiplexes, holds and writes again back to back, with the select and data inputs driven to misleading values during the hold and clear cycles. A complete sweep then covers all eight selects with both data values in each mode.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_LATCH = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_HOLD  = 2'b11
  } mode_e;
endpackage

// File: rtl/addr_latch_mode_dec.sv
module addr_latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic  en_ni,
  input  logic  clr_ni,
  output mode_e mode_o
);
  // R2: {enable, clear} pair maps directly onto the mode encoding
  assign mode_o = mode_e'({en_ni, clr_ni});
endmodule

// File: rtl/addr_latch_onehot.sv
module addr_latch_onehot #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     hot_o
);
  for (genvar k = 0; k < N; k++) begin : g_hot
    assign hot_o[k] = (sel_i == SEL_W'(k));  // R8: value k selects bit k
  end
endmodule

// File: rtl/addr_latch_dec.sv
module addr_latch_dec
  import addr_latch_pkg::*;
#(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             clr_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             d_i,
  output logic [N-1:0]     q_o
);
  mode_e          mode;
  logic [N-1:0]   hot;
  logic [N-1:0]   q_q, q_d;

  addr_latch_mode_dec u_mode (.en_ni(en_ni), .clr_ni(clr_ni), .mode_o(mode));
  addr_latch_onehot #(.SEL_W(SEL_W)) u_hot (.sel_i(sel_i), .hot_o(hot));

  always_comb begin
    unique case (mode)
      MODE_LATCH: q_d = (q_q & ~hot) | (hot & {N{d_i}});
      MODE_DEMUX: q_d = hot & {N{d_i}};  // overwrites storage
      MODE_CLEAR: q_d = '0;
      default:    q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  a_r1_reset_zero: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni && clr_ni) |=> $stable(q_o));
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni && !clr_ni) |=> q_o == '0);
  a_r5_demux_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && !clr_ni) |=> $onehot0(q_o));
  a_r5_demux_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && !clr_ni) |=> q_o[$past(sel_i)] == $past(d_i));
  a_r3_latch_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && clr_ni) |=> q_o[$past(sel_i)] == $past(d_i));
  a_r9_latch_one_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && clr_ni) |=> $countones(q_o ^ $past(q_o)) <= 1);
endmodule

// File: tb/addr_latch_dec_test.sv
module addr_latch_dec_test;
  logic clk = 0, rst_n = 0, en_n = 1, clr_n = 1, d = 0;
  logic [2:0] sel = 0;
  logic [7:0] q;
  int n_chk = 0, n_bad = 0;
  logic [7:0] model = 0;

  always #5 clk = ~clk;

  addr_latch_dec uut (.clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .clr_ni(clr_n),
                      .sel_i(sel), .d_i(d), .q_o(q));

  // vector: {en_n, clr_n, sel[2:0], d, expected q[7:0]}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {2'b01, 3'd0, 1'b1, 8'h01},  // R3 latch bit0
    {2'b01, 3'd7, 1'b1, 8'h81},  // R8 bit7
    {2'b01, 3'd2, 1'b1, 8'h85},
    {2'b11, 3'd5, 1'b1, 8'h85},  // R4 hold ignores inputs
    {2'b01, 3'd0, 1'b0, 8'h84},  // R3 write 0
    {2'b00, 3'd4, 1'b1, 8'h10},  // R5 demux
    {2'b11, 3'd1, 1'b1, 8'h10},  // R7 held
    {2'b01, 3'd6, 1'b1, 8'h50},  // R7 latch on top
    {2'b00, 3'd3, 1'b0, 8'h00},  // R5 demux with 0
    {2'b01, 3'd1, 1'b1, 8'h02},
    {2'b10, 3'd1, 1'b1, 8'h00},  // R6 clear
    {2'b01, 3'd5, 1'b1, 8'h20},
    {2'b10, 3'd7, 1'b0, 8'h00},  // R6
    {2'b11, 3'd2, 1'b1, 8'h00}   // R4
  };

  task automatic check(input logic [7:0] exp, input string req);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%h expected %h", req, q, exp);
    end
  endtask

  task automatic apply(input logic e, input logic c, input logic [2:0] s, input logic dv);
    en_n = e; clr_n = c; sel = s; d = dv;
    @(posedge clk); #2;
    case ({e, c})
      2'b01: model[s] = dv;
      2'b00: begin model = 0; model[s] = dv; end
      2'b10: model = 0;
      default: ;
    endcase
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: q=%h expected completion", q);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3; check(8'h00, "R1");
    @(posedge clk); #2; check(8'h00, "R1");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2; check(8'h00, "R1");
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      check(VEC[i][7:0], "R2/R3/R4/R5/R6/R7 table");
    end
    // full sweep against model, back-to-back mode changes
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 8; s++)
        for (int b = 0; b < 2; b++) begin
          @(negedge clk);
          apply(m[1], m[0], s[2:0], b[0]);
          check(model, "R8 sweep");
          @(negedge clk);
          apply(~m[1], s[0], 3'(7 - s), ~b[0]);
          check(model, "R2 sweep");
        end
    // R9: fill, then latch a single bit
    @(negedge clk); apply(0, 1, 3'd3, 1); apply(0, 1, 3'd6, 1);
    check(model, "R9");
    // R1: async reset mid-run
    @(negedge clk); #1 rst_n = 0; #1 check(8'h00, "R1 async");
    model = 0;
    @(negedge clk); rst_n = 1;
    apply(1, 1, 3'd1, 1); check(8'h00, "R1 after release");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule